// File: doc/BRIEF.md
# Monitoring-Mode Debug Coprocessor

This block sits on a processor core's coprocessor port and carries debug commands and data between an external debugger and a service routine. The core runs that routine inside a debug exception, so its clock never stops. The debugger reaches the block through a register-access stream: a valid/ready request channel and a registered read-response strobe. That stream is taken to be already synchronous to the system clock. The core reaches the same registers through its coprocessor request signals. All state is clocked by the system clock.

The block holds four registers. The first is a 12-bit control word with a command part and two status bits. The other three are 32-bit: an address register and a write-data register, both filled by the debugger, and a read-data register filled by the core. Two acknowledge bits serialise the two sides. The debug-acknowledge bit (control bit 10) grants the core access. The core-acknowledge bit (control bit 0) tells the debugger that a result is ready. A typical exchange runs as follows. The debugger writes the address, then writes a command word such as 0xC10, which clears the core acknowledge. The routine reads the command and the address and writes the result. That write sets the core acknowledge. The debugger polls until bits 1 and 0 are both 1, then fetches the result.

Back-pressure: a debugger request addressing the control word is accepted in the cycle it is presented. A request addressing the address, write-data or read-data register is held with `dbg_ready` low until control bits 1 and 0 are both 1. The requester must keep its request stable while `dbg_ready` is low.

Top module: `mdc_top`

## Requirements
- R1: After reset, every register reads 0, `dbg_rvalid` is 0, `mon_en` is 0 and `in_debug_exc` is 0.
- R2: A debugger write with `dbg_sel`=0 (control) is always accepted. It stores bits 11:2 of `dbg_wdata`, forces bit 0 (core acknowledge) to 0 and leaves bit 1 (debug exception) unchanged. `mon_en` mirrors bit 11.
- R3: A one-cycle `exc_ack` while bit 11 is 1 sets bit 1 and bit 0 on the next edge. While bit 11 is 0, `exc_ack` has no effect.
- R4: While bit 10 is 0, a core request returns 0 on `cop_rdata` and a core write changes nothing, so the core acknowledge stays 0.
- R5: With bit 10 set, a core write to `cop_regnum`=3 stores `cop_wdata` in the read-data register and sets bit 0. The debugger can then read that value with `dbg_sel`=3.
- R6: A debugger request with `dbg_sel` of 1 (address), 2 (write data) or 3 (read data) sees `dbg_ready` high only while bits 1 and 0 are both 1. Otherwise it is held.
- R7: With bit 10 set, a core read returns the control word for `cop_regnum`=0, the address register for 1 and the write-data register for 2, combinationally in the same cycle.
- R8: A one-cycle `cop_exit` clears bit 1 when bit 2 (single-step/end) is 1. When bit 2 is 0 it has no effect.
- R9: An accepted debugger read raises `dbg_rvalid` for exactly the following cycle, with the data in `dbg_rdata`. An accepted write raises no `dbg_rvalid`.
- R10: If a debugger control write and a core read-data write land in the same cycle, the control write wins and bit 0 ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_valid | input | 1 | Debugger request valid |
| dbg_ready | output | 1 | Request accepted this cycle |
| dbg_write | input | 1 | 1 = write, 0 = read |
| dbg_sel | input | 2 | Register: 0 control, 1 address, 2 write data, 3 read data |
| dbg_wdata | input | 32 | Debugger write value |
| dbg_rvalid | output | 1 | Read response valid |
| dbg_rdata | output | 32 | Read response value |
| cop_req | input | 1 | Core coprocessor request |
| cop_write | input | 1 | Core request is a write |
| cop_regnum | input | 2 | Core register number (same coding as dbg_sel) |
| cop_wdata | input | 32 | Core write value |
| cop_rdata | output | 32 | Core read value |
| exc_ack | input | 1 | Core has entered the debug exception |
| cop_exit | input | 1 | Core is leaving the exception |
| mon_en | output | 1 | Monitoring mode enabled (bit 11) |
| in_debug_exc | output | 1 | Debug exception flag (bit 1) |

## Verification
The main command exchange is driven through four patterns: a memory command (0xC10), a status write (0xC28), a register command with index 4 (0xD10), and a single-step/end command (0xC04). Each pattern is followed by core-side reads and result writes. These show whether the command bits, the address and write-data paths and the acknowledge toggling move independently. Directed cases cover the negative patterns: an exception request with the enable clear, core traffic without the debug acknowledge, an exit request without the single-step bit, and a data access before the handshake completes. A control write collides with a core result write in the same cycle, which exposes the wrong priority.

// File: rtl/mdc_pkg.sv
`timescale 1ns/1ps
package mdc_pkg;
  localparam int CTRL_W   = 12;
  localparam int CMD_LSB  = 2;
  localparam int EN_BIT   = 11;
  localparam int DACK_BIT = 10;
  localparam int SS_BIT   = 2;
  localparam int DEXC_BIT = 1;
  localparam int CACK_BIT = 0;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_WDATA = 2'd2,
    SEL_RDATA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mdc_ctrl.sv
`timescale 1ns/1ps
module mdc_ctrl
  import mdc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_wr,
  input  logic [CTRL_W-1:CMD_LSB]   cmd_in,
  input  logic                      result_wr,
  input  logic                      exc_ack,
  input  logic                      core_exit,
  output logic [CTRL_W-1:0]         ctrl_q
);
  logic [CTRL_W-1:CMD_LSB] cmd_q;
  logic                    dexc_q;
  logic                    cack_q;
  logic                    enabled;
  logic                    ss_end;

  assign enabled = cmd_q[EN_BIT];
  assign ss_end  = cmd_q[SS_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      dexc_q <= 1'b0;
      cack_q <= 1'b0;
    end else begin
      if (cmd_wr)
        cmd_q <= cmd_in;
      // leaving the exception has priority over a fresh entry
      if (core_exit && ss_end)
        dexc_q <= 1'b0;
      else if (exc_ack && enabled)
        dexc_q <= 1'b1;
      // a new debugger command always withdraws the core acknowledge
      if (cmd_wr)
        cack_q <= 1'b0;
      else if ((exc_ack && enabled) || result_wr)
        cack_q <= 1'b1;
    end
  end

  assign ctrl_q = {cmd_q, dexc_q, cack_q};

  p_cmd_clears_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !ctrl_q[CACK_BIT]);
  p_cmd_keeps_exc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !exc_ack && !core_exit) |=> (ctrl_q[DEXC_BIT] == $past(ctrl_q[DEXC_BIT])));
  p_entry_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ack && ctrl_q[EN_BIT] && !(core_exit && ctrl_q[SS_BIT])) |=> ctrl_q[DEXC_BIT]);
  p_entry_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ack && !ctrl_q[EN_BIT] && !ctrl_q[DEXC_BIT]) |=> !ctrl_q[DEXC_BIT]);
  p_result_acks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (result_wr && !cmd_wr) |=> ctrl_q[CACK_BIT]);
  p_exit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_exit && ctrl_q[SS_BIT]) |=> !ctrl_q[DEXC_BIT]);
  p_exit_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_exit && !ctrl_q[SS_BIT] && ctrl_q[DEXC_BIT]) |=> ctrl_q[DEXC_BIT]);
  p_collision_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && result_wr) |=> !ctrl_q[CACK_BIT]);
endmodule

// File: rtl/mdc_data_regs.sv
`timescale 1ns/1ps
module mdc_data_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic              wdata_wr,
  input  logic [DATA_W-1:0] dbg_data,
  input  logic              result_wr,
  input  logic [DATA_W-1:0] core_data,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (addr_wr)   addr_q  <= dbg_data;
      if (wdata_wr)  wdata_q <= dbg_data;
      if (result_wr) rdata_q <= core_data;
    end
  end

  p_rdata_core_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !result_wr |=> $stable(rdata_q));
  p_addr_dbg_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_wr |=> $stable(addr_q));
endmodule

// File: rtl/mdc_core_port.sv
`timescale 1ns/1ps
module mdc_core_port
  import mdc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cop_req,
  input  logic              cop_write,
  input  logic [1:0]        cop_regnum,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [DATA_W-1:0] rdata_q,
  output logic              result_wr,
  output logic [DATA_W-1:0] cop_rdata
);
  localparam int PAD_W = DATA_W - CTRL_W;

  reg_sel_e sel;
  logic     granted;

  assign sel       = reg_sel_e'(cop_regnum);
  assign granted   = cop_req && ctrl_q[DACK_BIT];
  assign result_wr = granted && cop_write && (sel == SEL_RDATA);

  always_comb begin
    cop_rdata = '0;
    if (granted && !cop_write) begin
      unique case (sel)
        SEL_CTRL:  cop_rdata = {{PAD_W{1'b0}}, ctrl_q};
        SEL_ADDR:  cop_rdata = addr_q;
        SEL_WDATA: cop_rdata = wdata_q;
        SEL_RDATA: cop_rdata = rdata_q;
        default:   cop_rdata = '0;
      endcase
    end
  end

  p_no_grant_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_req && !ctrl_q[DACK_BIT]) |-> (cop_rdata == '0 && !result_wr));
endmodule

// File: rtl/mdc_dbg_port.sv
`timescale 1ns/1ps
module mdc_dbg_port
  import mdc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_valid,
  input  logic              dbg_write,
  input  logic [1:0]        dbg_sel,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [DATA_W-1:0] rdata_q,
  output logic              dbg_ready,
  output logic              dbg_rvalid,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              cmd_wr,
  output logic              addr_wr,
  output logic              wdata_wr
);
  localparam int PAD_W = DATA_W - CTRL_W;

  reg_sel_e    sel;
  logic        handshake_done;
  logic        accept;
  logic [DATA_W-1:0] rd_mux;

  assign sel            = reg_sel_e'(dbg_sel);
  assign handshake_done = ctrl_q[DEXC_BIT] && ctrl_q[CACK_BIT];
  assign dbg_ready      = (sel == SEL_CTRL) || handshake_done;
  assign accept         = dbg_valid && dbg_ready;

  assign cmd_wr   = accept && dbg_write && (sel == SEL_CTRL);
  assign addr_wr  = accept && dbg_write && (sel == SEL_ADDR);
  assign wdata_wr = accept && dbg_write && (sel == SEL_WDATA);

  always_comb begin
    unique case (sel)
      SEL_CTRL:  rd_mux = {{PAD_W{1'b0}}, ctrl_q};
      SEL_ADDR:  rd_mux = addr_q;
      SEL_WDATA: rd_mux = wdata_q;
      SEL_RDATA: rd_mux = rdata_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_rvalid <= 1'b0;
      dbg_rdata  <= '0;
    end else begin
      dbg_rvalid <= accept && !dbg_write;
      if (accept && !dbg_write)
        dbg_rdata <= rd_mux;
    end
  end

  p_ctrl_always_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_valid && dbg_sel == 2'd0) |-> dbg_ready);
  p_data_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_valid && dbg_sel != 2'd0 && !(ctrl_q[1] && ctrl_q[0])) |-> !dbg_ready);
  p_read_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_valid && dbg_ready && !dbg_write) |=> dbg_rvalid);
  p_no_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_valid && dbg_ready && !dbg_write) |=> !dbg_rvalid);
endmodule

// File: rtl/mdc_top.sv
`timescale 1ns/1ps
module mdc_top
  import mdc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_valid,
  output logic              dbg_ready,
  input  logic              dbg_write,
  input  logic [1:0]        dbg_sel,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic              dbg_rvalid,
  output logic [DATA_W-1:0] dbg_rdata,
  input  logic              cop_req,
  input  logic              cop_write,
  input  logic [1:0]        cop_regnum,
  input  logic [DATA_W-1:0] cop_wdata,
  output logic [DATA_W-1:0] cop_rdata,
  input  logic              exc_ack,
  input  logic              cop_exit,
  output logic              mon_en,
  output logic              in_debug_exc
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
  logic cmd_wr, addr_wr, wdata_wr, result_wr;

  mdc_dbg_port #(.DATA_W(DATA_W)) u_dbg (
    .clk(clk), .rst_n(rst_n), .dbg_valid(dbg_valid), .dbg_write(dbg_write),
    .dbg_sel(dbg_sel), .ctrl_q(ctrl_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .rdata_q(rdata_q), .dbg_ready(dbg_ready), .dbg_rvalid(dbg_rvalid),
    .dbg_rdata(dbg_rdata), .cmd_wr(cmd_wr), .addr_wr(addr_wr), .wdata_wr(wdata_wr)
  );

  mdc_core_port #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cop_req(cop_req), .cop_write(cop_write),
    .cop_regnum(cop_regnum), .ctrl_q(ctrl_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .rdata_q(rdata_q), .result_wr(result_wr), .cop_rdata(cop_rdata)
  );

  mdc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_in(dbg_wdata[CTRL_W-1:CMD_LSB]),
    .result_wr(result_wr), .exc_ack(exc_ack), .core_exit(cop_exit), .ctrl_q(ctrl_q)
  );

  mdc_data_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .wdata_wr(wdata_wr),
    .dbg_data(dbg_wdata), .result_wr(result_wr), .core_data(cop_wdata),
    .addr_q(addr_q), .wdata_q(wdata_q), .rdata_q(rdata_q)
  );

  assign mon_en       = ctrl_q[EN_BIT];
  assign in_debug_exc = ctrl_q[DEXC_BIT];
endmodule

// File: tb/mdc_top_tb_top.sv
`timescale 1ns/1ps
module mdc_top_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] OP_DWR  = 3'd0;
  localparam logic [2:0] OP_DRD  = 3'd1;
  localparam logic [2:0] OP_CWR  = 3'd2;
  localparam logic [2:0] OP_CRD  = 3'd3;
  localparam logic [2:0] OP_EXC  = 3'd4;
  localparam logic [2:0] OP_EXIT = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sel;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{OP_DWR,  2'd0, 32'h800,      32'h0,        4'd2},
    '{OP_DRD,  2'd0, 32'h0,        32'h800,      4'd2},
    '{OP_EXC,  2'd0, 32'h0,        32'h0,        4'd3},
    '{OP_DRD,  2'd0, 32'h0,        32'h803,      4'd3},
    '{OP_DWR,  2'd1, 32'h1000,     32'h0,        4'd6},
    '{OP_DWR,  2'd0, 32'hC10,      32'h0,        4'd2},
    '{OP_DRD,  2'd0, 32'h0,        32'hC12,      4'd2},
    '{OP_CRD,  2'd0, 32'h0,        32'hC12,      4'd7},
    '{OP_CRD,  2'd1, 32'h0,        32'h1000,     4'd7},
    '{OP_CWR,  2'd3, 32'hDEADBEEF, 32'h0,        4'd5},
    '{OP_DRD,  2'd0, 32'h0,        32'hC13,      4'd5},
    '{OP_DRD,  2'd3, 32'h0,        32'hDEADBEEF, 4'd5},
    '{OP_DWR,  2'd2, 32'h12345678, 32'h0,        4'd6},
    '{OP_DWR,  2'd0, 32'hC28,      32'h0,        4'd2},
    '{OP_CRD,  2'd2, 32'h0,        32'h12345678, 4'd7},
    '{OP_CWR,  2'd3, 32'h0,        32'h0,        4'd5},
    '{OP_DWR,  2'd0, 32'hD10,      32'h0,        4'd2},
    '{OP_CRD,  2'd0, 32'h0,        32'hD12,      4'd7},
    '{OP_CWR,  2'd3, 32'h55,       32'h0,        4'd5},
    '{OP_DRD,  2'd3, 32'h0,        32'h55,       4'd5},
    '{OP_EXIT, 2'd0, 32'h0,        32'h0,        4'd8},
    '{OP_DRD,  2'd0, 32'h0,        32'hD13,      4'd8},
    '{OP_DWR,  2'd0, 32'hC04,      32'h0,        4'd2},
    '{OP_EXIT, 2'd0, 32'h0,        32'h0,        4'd8},
    '{OP_DRD,  2'd0, 32'h0,        32'hC04,      4'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_valid = 1'b0, dbg_write = 1'b0;
  logic [1:0] dbg_sel = 2'd0;
  logic [31:0] dbg_wdata = '0;
  logic dbg_ready, dbg_rvalid;
  logic [31:0] dbg_rdata;
  logic cop_req = 1'b0, cop_write = 1'b0;
  logic [1:0] cop_regnum = 2'd0;
  logic [31:0] cop_wdata = '0;
  logic [31:0] cop_rdata;
  logic exc_ack = 1'b0, cop_exit = 1'b0;
  logic mon_en, in_debug_exc;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdc_top dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_valid(dbg_valid), .dbg_ready(dbg_ready),
    .dbg_write(dbg_write), .dbg_sel(dbg_sel), .dbg_wdata(dbg_wdata),
    .dbg_rvalid(dbg_rvalid), .dbg_rdata(dbg_rdata), .cop_req(cop_req),
    .cop_write(cop_write), .cop_regnum(cop_regnum), .cop_wdata(cop_wdata),
    .cop_rdata(cop_rdata), .exc_ack(exc_ack), .cop_exit(cop_exit),
    .mon_en(mon_en), .in_debug_exc(in_debug_exc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic dbg_op(input logic wr, input logic [1:0] sel, input logic [31:0] d,
                        output logic [31:0] rd, output logic rv);
    int tries;
    @(negedge clk);
    dbg_valid = 1'b1; dbg_write = wr; dbg_sel = sel; dbg_wdata = d;
    tries = 0;
    #1;
    while (!dbg_ready && tries < 50) begin
      @(negedge clk); #1; tries++;
    end
    if (!dbg_ready) begin
      n_checks++; n_fails++;
      $display("FAIL R6: request never accepted, actual ready 0 expected 1");
    end
    @(posedge clk);
    @(negedge clk);
    dbg_valid = 1'b0;
    rv = dbg_rvalid;
    rd = dbg_rdata;
  endtask

  task automatic cop_op(input logic wr, input logic [1:0] rn, input logic [31:0] d,
                        output logic [31:0] rd);
    @(negedge clk);
    cop_req = 1'b1; cop_write = wr; cop_regnum = rn; cop_wdata = d;
    #1 rd = cop_rdata;
    @(posedge clk);
    @(negedge clk);
    cop_req = 1'b0; cop_write = 1'b0;
  endtask

  task automatic pulse(input logic is_exit);
    @(negedge clk);
    if (is_exit) cop_exit = 1'b1; else exc_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cop_exit = 1'b0; exc_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic rv;
    do_reset();
    // R1: reset state
    check("R1 rvalid", {31'd0, dbg_rvalid}, 32'd0);
    check("R1 mon_en", {31'd0, mon_en}, 32'd0);
    check("R1 in_debug_exc", {31'd0, in_debug_exc}, 32'd0);
    dbg_op(1'b0, 2'd0, 32'h0, rd, rv);
    check("R1 ctrl", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec %0d", v.req, i);
      case (v.op)
        OP_DWR: begin
          dbg_op(1'b1, v.sel, v.data, rd, rv);
        end
        OP_DRD: begin
          dbg_op(1'b0, v.sel, 32'h0, rd, rv);
          check(tag, rd, v.exp);
        end
        OP_CWR: cop_op(1'b1, v.sel, v.data, rd);
        OP_CRD: begin
          cop_op(1'b0, v.sel, 32'h0, rd);
          check(tag, rd, v.exp);
        end
        OP_EXC:  pulse(1'b0);
        default: pulse(1'b1);
      endcase
    end
    check("R8 in_debug_exc after exit", {31'd0, in_debug_exc}, 32'd0);
    check("R2 mon_en", {31'd0, mon_en}, 32'd1);

    // R9: a write produces no read response
    dbg_op(1'b1, 2'd0, 32'hC04, rd, rv);
    check("R9 no rvalid on write", {31'd0, rv}, 32'd0);
    dbg_op(1'b0, 2'd0, 32'h0, rd, rv);
    check("R9 rvalid on read", {31'd0, rv}, 32'd1);

    // R6: data access held while the exception flag is clear
    @(negedge clk);
    dbg_valid = 1'b1; dbg_write = 1'b0; dbg_sel = 2'd3;
    for (int k = 0; k < 3; k++) begin
      #1 check("R6 held, no exception", {31'd0, dbg_ready}, 32'd0);
      @(negedge clk);
    end
    dbg_valid = 1'b0;

    // R3: exception request ignored while disabled
    do_reset();
    pulse(1'b0);
    check("R3 ignored flag", {31'd0, in_debug_exc}, 32'd0);
    dbg_op(1'b0, 2'd0, 32'h0, rd, rv);
    check("R3 ignored ctrl", rd, 32'h0);

    // R4: core locked out without debug acknowledge
    dbg_op(1'b1, 2'd0, 32'h800, rd, rv);
    pulse(1'b0);
    dbg_op(1'b1, 2'd0, 32'h810, rd, rv);
    cop_op(1'b0, 2'd0, 32'h0, rd);
    check("R4 core read blocked", rd, 32'h0);
    cop_op(1'b1, 2'd3, 32'h99, rd);
    dbg_op(1'b0, 2'd0, 32'h0, rd, rv);
    check("R4 core write ignored", rd, 32'h812);
    // R6: exception set but acknowledge clear still holds data access
    @(negedge clk);
    dbg_valid = 1'b1; dbg_write = 1'b0; dbg_sel = 2'd1;
    #1 check("R6 held, no core ack", {31'd0, dbg_ready}, 32'd0);
    @(negedge clk);
    dbg_valid = 1'b0;

    // R10: command write collides with core result write
    dbg_op(1'b1, 2'd0, 32'hC10, rd, rv);
    cop_op(1'b1, 2'd3, 32'hAB, rd);
    @(negedge clk);
    dbg_valid = 1'b1; dbg_write = 1'b1; dbg_sel = 2'd0; dbg_wdata = 32'hC10;
    cop_req = 1'b1; cop_write = 1'b1; cop_regnum = 2'd3; cop_wdata = 32'hCD;
    @(posedge clk);
    @(negedge clk);
    dbg_valid = 1'b0; cop_req = 1'b0; cop_write = 1'b0;
    dbg_op(1'b0, 2'd0, 32'h0, rd, rv);
    check("R10 command wins", rd, 32'hC12);
    cop_op(1'b1, 2'd3, 32'hEF, rd);
    dbg_op(1'b0, 2'd3, 32'h0, rd, rv);
    check("R5 result after collision", rd, 32'hEF);

    finish_run();
  end
endmodule